// File: doc/BRIEF.md
# Three-Channel Interval Timer Register Front End

This block is the byte-wide register front end of a three-channel interval timer. It sits between a host bus and three counter cores that it does not contain. The host reaches it through a two-bit port address. Ports 0, 1 and 2 are the data ports of channels 0, 1 and 2, and port 3 accepts control bytes. The block keeps, for each channel, the access mode, the counting mode and the BCD flag that the host programs. It assembles reload values from byte writes and hands each finished value to the matching counter core with a one-cycle load strobe.

On the read side it answers data-port reads with one of three things, in this order of preference: a captured status byte, a captured count, or the live count of the core. Captures come from two places. The per-channel latch command takes a count. The multi-channel read-back command can take counts, statuses or both. Reads and writes have separate strobes and separate addresses, so a read and a control write can arrive in the same cycle. Counting, gate handling and BCD arithmetic stay in the cores.

Top module: `pit_bus_ctrl`

## Requirements
- R1: In a control byte written to port 3, bits 7:6 select the channel and bits 5:4 give the access mode (1 = low byte only, 2 = high byte only, 3 = low then high). Bits 3:1 give the counting mode and bit 0 the BCD flag. A control byte with a nonzero access mode and a channel field below 3 updates that channel's `ch_mode` and `ch_bcd` outputs from the next cycle. It also returns both byte pointers of that channel to the low byte.
- R2: A control byte with access mode 0 and a channel field below 3 captures that channel's live count. The captured count is returned on later reads, in place of the live count, until it has been read completely.
- R3: A control byte with channel field 3 is a read-back command. Bit 1, bit 2 and bit 3 select channels 0, 1 and 2. Bit 5 = 0 captures the count of each selected channel, and bit 4 = 0 captures its status.
- R4: A status byte has the output level in bit 7, a 0 in bit 6, the access mode in bits 5:4, the counting mode in bits 3:1 and the BCD flag in bit 0.
- R5: While a captured status is unread, further status captures for that channel are ignored. A data read returns a pending status before anything else and clears only the status.
- R6: While a captured count is unread, further count captures for that channel are ignored. A captured count is consumed by one read in the single-byte modes (low or high byte as the mode says), or by a low-byte read followed by a high-byte read in word mode.
- R7: In word mode the first data write is held. The second data write supplies the high byte, loads the combined value and returns the write pointer to the low byte. The first write issues no load.
- R8: In low-only mode a data write loads the byte. In high-only mode it loads the byte shifted left by 8. A value of 0 is loaded as 65536. `load_stb` pulses for exactly one cycle, in the cycle after the write, and only for the addressed channel, with `load_val` valid in that cycle.
- R9: With no capture pending, a data read returns the live count: the low byte in low-only mode, the high byte in high-only mode, and alternately the low and high byte in word mode, starting with the low byte.
- R10: A read from port 3 returns 0xFF and changes no state.
- R11: When a data read and a capture command for the same channel fall in the same cycle, the read returns the value held before the edge. The capture is then judged against the state the read leaves behind.
- R12: After a synchronous active-high reset, every channel is in word access mode with counting mode 3, BCD flag 0, no pending captures and both pointers on the low byte. `load_stb` is 0, and `rdata` is 0 while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write port address (3 = control) |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read port address |
| rdata | output | 8 | Read byte, valid in the cycle of `rd_en` |
| cnt_live | input | 3x16 | Live count from each counter core |
| cnt_out | input | 3 | Output level of each counter core |
| load_stb | output | 3 | One-cycle reload strobe per core |
| load_val | output | 3x17 | Reload value per core (1 to 65536) |
| ch_mode | output | 3x3 | Counting mode per core |
| ch_bcd | output | 3 | BCD flag per core |

## Verification
A data read that consumes a capture can share a cycle with a control byte that requests a new capture on the same channel. The bench provokes this by raising both strobes in one cycle. In low-byte mode this is the final read of a captured count, so the new capture must be accepted. The following read must then show the count sampled in that cycle, not the current live value. In word mode the same-cycle read of the low byte leaves the capture half read, so the new request must be ignored and the high byte of the old capture must follow.

// File: rtl/pit_bus_pkg.sv
package pit_bus_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int LOAD_W = CNT_W + 1;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_LO   = 2'd1,
    CAP_HI   = 2'd2,
    CAP_WORD = 2'd3
  } cap_t;

  // value handed to a core for a data write in the given access mode
  function automatic logic [LOAD_W-1:0] reload_value(
    input acc_t acc, input logic [BYTE_W-1:0] held, input logic [BYTE_W-1:0] b);
    logic [CNT_W-1:0] raw;
    case (acc)
      ACC_LO:  raw = {{BYTE_W{1'b0}}, b};
      ACC_HI:  raw = {b, {BYTE_W{1'b0}}};
      default: raw = {b, held};
    endcase
    if (raw == '0) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, raw};
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(
    input logic out_lvl, input acc_t acc, input logic [2:0] mode, input logic bcd);
    return {out_lvl, 1'b0, acc, mode, bcd};
  endfunction

  function automatic logic [BYTE_W-1:0] count_byte(
    input logic [CNT_W-1:0] cnt, input logic hi);
    return hi ? cnt[CNT_W-1:BYTE_W] : cnt[BYTE_W-1:0];
  endfunction

  function automatic cap_t cap_of(input acc_t acc);
    return cap_t'(acc);
  endfunction
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode #(
  parameter int NCH = 3
) (
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [7:1]     ctl,
  output logic [NCH-1:0] data_wr,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] cnt_req,
  output logic [NCH-1:0] sts_req
);
  localparam logic [1:0] CTRL_PORT = 2'd3;
  localparam logic [1:0] RB_SEL    = 2'd3;

  logic       ctl_wr;
  logic [1:0] sel;
  logic [1:0] acc;
  logic       readback;

  assign ctl_wr   = wr_en && (wr_addr == CTRL_PORT);
  assign sel      = ctl[7:6];
  assign acc      = ctl[5:4];
  assign readback = ctl_wr && (sel == RB_SEL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic mine;
    logic rb_pick;
    assign mine       = ctl_wr && (sel == i[1:0]);
    assign rb_pick    = readback && ctl[i+1];
    assign data_wr[i] = wr_en && (wr_addr == i[1:0]);
    assign prog[i]    = mine && (acc != 2'd0);
    assign cnt_req[i] = (mine && (acc == 2'd0)) || (rb_pick && !ctl[5]);
    assign sts_req[i] = rb_pick && !ctl[4];
  end
endmodule

// File: rtl/pit_chan_regs.sv
module pit_chan_regs
  import pit_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              data_wr,
  input  logic              prog,
  input  logic              cnt_req,
  input  logic              sts_req,
  input  logic              rd_evt,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load_stb,
  output logic [LOAD_W-1:0] load_val,
  output logic [2:0]        mode,
  output logic              bcd
);
  acc_t              acc;
  logic              rd_hi, wr_hi;
  logic [BYTE_W-1:0] held;
  cap_t              cap;
  logic [CNT_W-1:0]  cap_val;
  logic              sts_pend;
  logic [BYTE_W-1:0] sts_val;

  // named events
  logic cnt_rd, live_rd, cap_after_free, sts_after_free;
  logic cnt_take, sts_take, load_now;
  cap_t cap_after_rd;

  assign cnt_rd  = rd_evt && !sts_pend && (cap != CAP_NONE);
  assign live_rd = rd_evt && !sts_pend && (cap == CAP_NONE);

  always_comb begin
    cap_after_rd = cap;
    if (cnt_rd) cap_after_rd = (cap == CAP_WORD) ? CAP_HI : CAP_NONE;
  end

  assign cap_after_free = (cap_after_rd == CAP_NONE);
  assign sts_after_free = rd_evt || !sts_pend;
  assign cnt_take       = cnt_req && cap_after_free;
  assign sts_take       = sts_req && sts_after_free;
  assign load_now       = data_wr && ((acc != ACC_WORD) || wr_hi);

  always_comb begin
    if (sts_pend)
      rd_byte = sts_val;
    else if (cap != CAP_NONE)
      rd_byte = count_byte(cap_val, cap == CAP_HI);
    else
      rd_byte = count_byte(live_cnt, (acc == ACC_HI) || ((acc == ACC_WORD) && rd_hi));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= ACC_WORD;
      mode     <= 3'd3;
      bcd      <= 1'b0;
      rd_hi    <= 1'b0;
      wr_hi    <= 1'b0;
      held     <= '0;
      cap      <= CAP_NONE;
      cap_val  <= '0;
      sts_pend <= 1'b0;
      sts_val  <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      // read side
      if (live_rd && (acc == ACC_WORD)) rd_hi <= !rd_hi;
      cap      <= cap_after_rd;
      sts_pend <= sts_pend && !rd_evt;
      // captures, judged after the read
      if (cnt_take) begin
        cap     <= cap_of(acc);
        cap_val <= live_cnt;
      end
      if (sts_take) begin
        sts_pend <= 1'b1;
        sts_val  <= status_byte(out_lvl, acc, mode, bcd);
      end
      // write side
      load_stb <= load_now;
      if (data_wr) begin
        load_val <= reload_value(acc, held, wdata);
        if (acc == ACC_WORD) begin
          wr_hi <= !wr_hi;
          if (!wr_hi) held <= wdata;
        end
      end
      if (prog) begin
        acc   <= acc_t'(wdata[5:4]);
        mode  <= wdata[3:1];
        bcd   <= wdata[0];
        rd_hi <= 1'b0;
        wr_hi <= 1'b0;
      end
    end
  end

  AST_CNT_CAP_HELD: assert property (@(posedge clk) disable iff (rst)
    ((cap != CAP_NONE) && cnt_req && !cnt_rd) |=> $stable(cap_val)) else $error("cap"); // R6
  AST_STS_CAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (sts_pend && sts_req && !rd_evt) |=> (sts_pend && $stable(sts_val))) else $error("sts"); // R5
  AST_STS_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && sts_pend && (cap != CAP_NONE)) |=> (cap != CAP_NONE)) else $error("keep"); // R5
  AST_WORD_FIRST_NOLOAD: assert property (@(posedge clk) disable iff (rst)
    (data_wr && (acc == ACC_WORD) && !wr_hi) |=> !load_stb) else $error("word"); // R7
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (load_val != '0)) else $error("zero"); // R8
endmodule

// File: rtl/pit_rd_mux.sv
module pit_rd_mux
  import pit_bus_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                         rd_en,
  input  logic [1:0]                   rd_addr,
  input  logic [NCH-1:0][BYTE_W-1:0]   rd_bytes,
  output logic [NCH-1:0]               rd_evt,
  output logic [BYTE_W-1:0]            rdata
);
  localparam logic [BYTE_W-1:0] NO_DATA = '1;

  for (genvar i = 0; i < NCH; i++) begin : g_ev
    assign rd_evt[i] = rd_en && (rd_addr == i[1:0]);
  end

  always_comb begin
    rdata = rd_en ? NO_DATA : '0;
    for (int i = 0; i < NCH; i++)
      if (rd_evt[i]) rdata = rd_bytes[i];
  end
endmodule

// File: rtl/pit_bus_ctrl.sv
module pit_bus_ctrl
  import pit_bus_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_addr,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic                       rd_en,
  input  logic [1:0]                 rd_addr,
  output logic [BYTE_W-1:0]          rdata,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt_live,
  input  logic [NCH-1:0]             cnt_out,
  output logic [NCH-1:0]             load_stb,
  output logic [NCH-1:0][LOAD_W-1:0] load_val,
  output logic [NCH-1:0][2:0]        ch_mode,
  output logic [NCH-1:0]             ch_bcd
);
  logic [NCH-1:0]             data_wr, prog, cnt_req, sts_req, rd_evt;
  logic [NCH-1:0][BYTE_W-1:0] rd_bytes;

  pit_ctrl_decode #(.NCH(NCH)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .ctl(wdata[7:1]),
    .data_wr(data_wr), .prog(prog), .cnt_req(cnt_req), .sts_req(sts_req)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pit_chan_regs u_ch (
      .clk(clk), .rst(rst), .wdata(wdata),
      .data_wr(data_wr[i]), .prog(prog[i]), .cnt_req(cnt_req[i]),
      .sts_req(sts_req[i]), .rd_evt(rd_evt[i]),
      .live_cnt(cnt_live[i]), .out_lvl(cnt_out[i]),
      .rd_byte(rd_bytes[i]), .load_stb(load_stb[i]), .load_val(load_val[i]),
      .mode(ch_mode[i]), .bcd(ch_bcd[i])
    );
  end

  pit_rd_mux #(.NCH(NCH)) u_rd (
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
    .rd_evt(rd_evt), .rdata(rdata)
  );

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_stb)) else $error("multi load"); // R8
  AST_LOAD_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr != 2'd3)) |=> (load_stb == '0)) else $error("stray load"); // R8
endmodule

// File: tb/pit_bus_ctrl_tb.sv
module pit_bus_ctrl_tb;
  localparam int NCH = 3;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NCH-1:0][15:0] cnt_live;
  logic [NCH-1:0] cnt_out;
  logic [NCH-1:0] load_stb;
  logic [NCH-1:0][16:0] load_val;
  logic [NCH-1:0][2:0] ch_mode;
  logic [NCH-1:0] ch_bcd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  pit_bus_ctrl #(.NCH(NCH)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic both(input logic [1:0] ra, input logic [1:0] wa, input logic [7:0] d, output logic [7:0] v);
    @(negedge clk); rd_en = 1; rd_addr = ra; wr_en = 1; wr_addr = wa; wdata = d; #1 v = rdata;
    @(negedge clk); rd_en = 0; wr_en = 0;
  endtask

  // entry: op[32:31] addr[30:29] data[28:21] exp[20:4] req[3:0]
  // op 0 = write, no load; 1 = write, load exp; 2 = read, expect exp[7:0]
  localparam int NV = 24;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 2'd3, 8'h34, 17'h00000, 4'd1},  // R1 ch0 word, mode 2
    {2'd0, 2'd0, 8'h00, 17'h00000, 4'd7},  // R7 first byte held
    {2'd1, 2'd0, 8'h00, 17'h10000, 4'd8},  // R8 zero -> 65536
    {2'd0, 2'd0, 8'h78, 17'h00000, 4'd7},  // R7
    {2'd1, 2'd0, 8'h56, 17'h05678, 4'd7},  // R7 combined
    {2'd0, 2'd3, 8'h50, 17'h00000, 4'd1},  // R1 ch1 low only
    {2'd1, 2'd1, 8'h9A, 17'h0009A, 4'd8},  // R8 low only
    {2'd0, 2'd3, 8'hA7, 17'h00000, 4'd1},  // R1 ch2 high only, bcd
    {2'd1, 2'd2, 8'h12, 17'h01200, 4'd8},  // R8 high only
    {2'd2, 2'd0, 8'h00, 17'h00034, 4'd9},  // R9 word low
    {2'd2, 2'd0, 8'h00, 17'h00012, 4'd9},  // R9 word high
    {2'd2, 2'd0, 8'h00, 17'h00034, 4'd9},  // R9 toggles back
    {2'd2, 2'd1, 8'h00, 17'h000CD, 4'd9},  // R9 low only
    {2'd2, 2'd2, 8'h00, 17'h0000F, 4'd9},  // R9 high only
    {2'd0, 2'd3, 8'h00, 17'h00000, 4'd2},  // R2 latch ch0
    {2'd2, 2'd3, 8'h00, 17'h000FF, 4'd10}, // R10 port 3 read
    {2'd2, 2'd0, 8'h00, 17'h00034, 4'd2},  // R2 captured low
    {2'd2, 2'd0, 8'h00, 17'h00012, 4'd2},  // R2 captured high
    {2'd0, 2'd3, 8'hE2, 17'h00000, 4'd3},  // R3 status ch0
    {2'd2, 2'd0, 8'h00, 17'h000B4, 4'd4},  // R4 status byte
    {2'd2, 2'd0, 8'h00, 17'h00012, 4'd9},  // R9 pointer kept across captures
    {2'd0, 2'd3, 8'hEC, 17'h00000, 4'd3},  // R3 status ch1+ch2
    {2'd2, 2'd2, 8'h00, 17'h00027, 4'd4},  // R4 ch2
    {2'd2, 2'd1, 8'h00, 17'h00010, 4'd4}   // R4 ch1
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cnt_live[0] = 16'h1234; cnt_live[1] = 16'hABCD; cnt_live[2] = 16'h0F5A;
    cnt_out = 3'b001;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R12 reset state
    chk(ch_mode == {3'd3, 3'd3, 3'd3}, "R12 mode", ch_mode, 9'o333);
    chk(ch_bcd == 3'b000 && load_stb == 3'b000, "R12 bcd/load", {ch_bcd, load_stb}, 0);
    chk(rdata == 8'h00, "R12 rdata idle", rdata, 0);
    rd(2'd0, got); chk(got == 8'h34, "R12 word low first", got, 8'h34);
    rd(2'd0, got); chk(got == 8'h12, "R12 word high", got, 8'h12);

    for (int k = 0; k < NV; k++) begin
      logic [1:0] op, a; logic [7:0] d; logic [16:0] e; logic [3:0] rq;
      {op, a, d, e, rq} = VEC[k];
      if (op == 2'd2) begin
        rd(a, got);
        chk(got == e[7:0], $sformatf("R%0d vec %0d read", rq, k), got, e[7:0]);
      end else begin
        wr(a, d); #1;
        if (op == 2'd1)
          chk(load_stb == (3'b001 << a) && load_val[a] == e,
              $sformatf("R%0d vec %0d load", rq, k), {load_stb, load_val[a]}, {3'b001 << a, e});
        else
          chk(load_stb == 3'b000, $sformatf("R%0d vec %0d no load", rq, k), load_stb, 0);
        @(negedge clk); #1;
        chk(load_stb == 3'b000, $sformatf("R%0d vec %0d strobe one cycle", rq, k), load_stb, 0);
      end
    end

    // R1 outputs follow control bytes
    chk(ch_mode[2] == 3'd3 && ch_bcd[2] && ch_mode[1] == 3'd0 && ch_mode[0] == 3'd2,
        "R1 mode/bcd outputs", {ch_mode, ch_bcd}, {9'o302, 3'b100});

    // R6 repeat latch ignored
    wr(2'd3, 8'h34); wr(2'd3, 8'h00);
    cnt_live[0] = 16'hBEEF;
    wr(2'd3, 8'h00);
    rd(2'd0, got); chk(got == 8'h34, "R6 held low", got, 8'h34);
    rd(2'd0, got); chk(got == 8'h12, "R6 held high", got, 8'h12);
    rd(2'd0, got); chk(got == 8'hEF, "R6 live after consume", got, 8'hEF);

    // R5 repeat status ignored, then fresh status shows new level
    wr(2'd3, 8'hE4);
    cnt_out = 3'b011;
    wr(2'd3, 8'hE4);
    rd(2'd1, got); chk(got == 8'h10, "R5 old status", got, 8'h10);
    rd(2'd1, got); chk(got == 8'hCD, "R5 status cleared", got, 8'hCD);
    wr(2'd3, 8'hE4);
    rd(2'd1, got); chk(got == 8'h90, "R4 output bit", got, 8'h90);

    // R3 count-only read-back
    wr(2'd3, 8'hD2);
    cnt_live[0] = 16'h1111;
    rd(2'd0, got); chk(got == 8'hEF, "R3 count low", got, 8'hEF);
    rd(2'd0, got); chk(got == 8'hBE, "R3 count high", got, 8'hBE);

    // R5 status before count on one channel
    wr(2'd3, 8'hC8);
    cnt_live[2] = 16'h7700;
    rd(2'd2, got); chk(got == 8'h27, "R5 status first", got, 8'h27);
    rd(2'd2, got); chk(got == 8'h0F, "R5 then count", got, 8'h0F);
    rd(2'd2, got); chk(got == 8'h77, "R9 then live", got, 8'h77);

    // R11 final read and latch in one cycle: latch taken
    wr(2'd3, 8'h40);
    cnt_live[1] = 16'h0042;
    both(2'd1, 2'd3, 8'h40, got); chk(got == 8'hCD, "R11 old value read", got, 8'hCD);
    cnt_live[1] = 16'h0099;
    rd(2'd1, got); chk(got == 8'h42, "R11 new capture", got, 8'h42);
    rd(2'd1, got); chk(got == 8'h99, "R11 live after", got, 8'h99);

    // R11 partial word read and latch in one cycle: latch ignored
    wr(2'd3, 8'h34); wr(2'd3, 8'h00);
    cnt_live[0] = 16'h2222;
    both(2'd0, 2'd3, 8'h00, got); chk(got == 8'h11, "R11 word low", got, 8'h11);
    cnt_live[0] = 16'h3333;
    rd(2'd0, got); chk(got == 8'h11, "R11 old high kept", got, 8'h11);
    rd(2'd0, got); chk(got == 8'h33, "R11 live resumes", got, 8'h33);

    // R8 high-only zero
    wr(2'd2, 8'h00); #1;
    chk(load_stb == 3'b100 && load_val[2] == 17'h10000, "R8 high zero", load_val[2], 17'h10000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule